// File: doc/BRIEF.md
# Self-Aligning Pseudo-Random Reference and Bit-Error Comparator

This block keeps a local replica of the maximal-length shift-register generator that produced a received test stream. It compares every received bit against that replica and accumulates error and bit totals. It relies on an external frame synchronizer for alignment. While the synchronizer hunts, its search pulse forces the replica into the register state that follows the sync word. The replica then stays frozen until the lock level rises. The first compared bit is therefore the bit after the sync word, whatever delay the receive path adds. No delay tuning is needed.

Each compared bit is judged one cycle later on an error strobe. Two saturating counters hold the number of compared bits and the number of mismatches. A synchronous clear resets both. A bit-enable input marks the system-clock cycles that carry a received bit. A parameter selects a 10-stage register (period 1023) or a 5-stage register (period 31).

Top module: `prbs_ref_comparator`

## Requirements
- R1: During and right after synchronous reset, both counters read 0, the error strobe is 0, and the reference bit equals stage N of the preset state, which is 1.
- R2: The register uses stages 1..N. On each shift, stage 1 takes stage 3 XOR stage N, stage k takes the old stage k-1, and `ref_bit_o` is stage N. With N=10 the output repeats every 1023 shifts and holds 512 ones per period.
- R3: In any cycle where `lock_i` is low and neither preset input is high, the register state and both counters are unchanged, whatever `rx_bit_i` and `bit_en_i` do.
- R4: A cycle with `search_i` high loads the preset state, which for N=10 is stages 1..10 = 0001010111. It overrides a shift in the same cycle, and no bit is compared in that cycle.
- R5: A cycle with `start_i` high has the same effect as `search_i`.
- R6: A bit is compared only in a cycle where `lock_i` and `bit_en_i` are both high and no preset input is high. `err_stb_o` is high in the cycle after such a bit exactly when `rx_bit_i` differed from `ref_bit_o`.
- R7: Each compared bit adds one to `bit_cnt_o`. Each mismatch adds one to `err_cnt_o`. `err_cnt_o` never exceeds `bit_cnt_o`.
- R8: Both counters stop at their all-ones value and do not wrap.
- R9: `cnt_clr_i` zeroes both counters on the next edge and takes priority over an increment in the same cycle. The error strobe is still produced.
- R10: With `lock_i` high and `bit_en_i` low, the register does not shift and nothing is counted.
- R11: If an identical generator feeds the input through any fixed delay with injected bit flips, then after one search pulse and lock on the post-sync bit, `err_cnt_o` equals the number of flips and `bit_cnt_o` equals the number of locked bits.
- R12: With N=5 the preset is stages 1..5 = 10011, the output period is 31, and each period holds 16 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Power-up initialise, loads the preset |
| search_i | input | 1 | Search pulse from the frame synchronizer, loads the preset |
| lock_i | input | 1 | Lock level from the frame synchronizer, enables shifting and comparing |
| bit_en_i | input | 1 | Marks cycles carrying a received bit |
| rx_bit_i | input | 1 | Received data bit |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| ref_bit_o | output | 1 | Current reference bit (stage N) |
| err_stb_o | output | 1 | One-cycle strobe for a mismatched compared bit |
| err_cnt_o | output | CNT_W | Saturating mismatch count |
| bit_cnt_o | output | CNT_W | Saturating compared-bit count |

## Verification
Two cases can fall in the same cycle. A counter clear can coincide with a compared bit that mismatches, and a search pulse can coincide with a locked, enabled bit. The bench drives clear together with a deliberately flipped bit and expects zero counts together with a raised strobe. It also drives search while locked and expects the preset reference, no strobe and no count. A scoreboard model built from the stage equations judges each result.

// File: rtl/prbs_ref_pkg.sv
package prbs_ref_pkg;

    localparam int unsigned MAX_STAGES = 15;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_PRESET = 2'd1,
        ACT_SHIFT  = 2'd2
    } ref_act_t;

    typedef struct packed {
        logic counted;
        logic mismatch;
    } cmp_res_t;

    // Preset state, bit k holds stage k+1.
    function automatic logic [15:0] preset_of(input int unsigned stages);
        logic [15:0] p;
        case (stages)
            10:      p = 16'h03A8;
            5:       p = 16'h0019;
            default: p = 16'h0001;
        endcase
        return p;
    endfunction

    function automatic int unsigned tap_of(input int unsigned stages);
        int unsigned t;
        case (stages)
            10:      t = 3;
            5:       t = 3;
            default: t = 1;
        endcase
        return t;
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] s,
                                              input int unsigned n,
                                              input int unsigned tap);
        logic [15:0] nx;
        for (int k = 0; k < 16; k++) begin
            if (k == 0)
                nx[k] = s[tap-1] ^ s[n-1];
            else if (k < int'(n))
                nx[k] = s[k-1];
            else
                nx[k] = 1'b0;
        end
        return nx;
    endfunction

endpackage

// File: rtl/prbs_ref_seq.sv
module prbs_ref_seq
    import prbs_ref_pkg::*;
#(
    parameter int unsigned STAGES = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     search_i,
    input  logic     lock_i,
    input  logic     bit_en_i,
    output ref_act_t act_o,
    output logic     ref_bit_o
);
    localparam logic [15:0]       PRE16  = preset_of(STAGES);
    localparam logic [STAGES-1:0] PRESET = PRE16[STAGES-1:0];
    localparam int unsigned       TAP    = tap_of(STAGES);

    logic [STAGES-1:0] state_q;
    logic [15:0]       wide_cur;
    logic [15:0]       wide_nxt;
    ref_act_t          act;

    always_comb begin
        if (start_i || search_i)
            act = ACT_PRESET;
        else if (lock_i && bit_en_i)
            act = ACT_SHIFT;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        wide_cur = '0;
        wide_cur[STAGES-1:0] = state_q;
        wide_nxt = lfsr_step(wide_cur, STAGES, TAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PRESET;
        end else begin
            case (act)
                ACT_PRESET: state_q <= PRESET;
                ACT_SHIFT:  state_q <= wide_nxt[STAGES-1:0];
                default:    state_q <= state_q;
            endcase
        end
    end

    assign act_o     = act;
    assign ref_bit_o = state_q[STAGES-1];

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !search_i && !(lock_i && bit_en_i)) |=> $stable(state_q))
        else $error("register moved without a shift");

    assert_preset_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i || search_i) |=> (state_q == PRESET))
        else $error("preset not loaded");

endmodule

// File: rtl/prbs_bit_cmp.sv
module prbs_bit_cmp
    import prbs_ref_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ref_act_t act_i,
    input  logic     rx_bit_i,
    input  logic     ref_bit_i,
    output cmp_res_t res_o,
    output logic     err_stb_o
);
    logic err_q;

    always_comb begin
        res_o.counted  = (act_i == ACT_SHIFT);
        res_o.mismatch = (act_i == ACT_SHIFT) && (rx_bit_i != ref_bit_i);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= res_o.mismatch;
    end

    assign err_stb_o = err_q;

    assert_strobe_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (act_i != ACT_SHIFT) |=> !err_stb_o)
        else $error("strobe without a compared bit");

endmodule

// File: rtl/prbs_sat_cnt.sv
module prbs_sat_cnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (inc_i && (cnt_q != TOP))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == TOP) && !clr_i) |=> (cnt_q == TOP))
        else $error("counter wrapped");

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0))
        else $error("clear ignored");

endmodule

// File: rtl/prbs_ref_comparator.sv
module prbs_ref_comparator
    import prbs_ref_pkg::*;
#(
    parameter int unsigned STAGES = 10,
    parameter int unsigned CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             search_i,
    input  logic             lock_i,
    input  logic             bit_en_i,
    input  logic             rx_bit_i,
    input  logic             cnt_clr_i,
    output logic             ref_bit_o,
    output logic             err_stb_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic [CNT_W-1:0] bit_cnt_o
);
    localparam int unsigned NUM_CNT = 2;

    ref_act_t act;
    logic     ref_bit;
    cmp_res_t res;
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;

    prbs_ref_seq #(.STAGES(STAGES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .search_i  (search_i),
        .lock_i    (lock_i),
        .bit_en_i  (bit_en_i),
        .act_o     (act),
        .ref_bit_o (ref_bit)
    );

    prbs_bit_cmp u_cmp (
        .clk       (clk),
        .rst       (rst),
        .act_i     (act),
        .rx_bit_i  (rx_bit_i),
        .ref_bit_i (ref_bit),
        .res_o     (res),
        .err_stb_o (err_stb_o)
    );

    assign inc_vec[0] = res.counted;
    assign inc_vec[1] = res.mismatch;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        prbs_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr_i (cnt_clr_i),
            .inc_i (inc_vec[g]),
            .cnt_o (cnt_vec[g])
        );
    end

    assign ref_bit_o = ref_bit;
    assign bit_cnt_o = cnt_vec[0];
    assign err_cnt_o = cnt_vec[1];

    assert_err_le_bits_R7: assert property (@(posedge clk) disable iff (rst)
        err_cnt_o <= bit_cnt_o)
        else $error("more errors than compared bits");

endmodule

// File: tb/prbs_ref_comparator_bench.sv
`timescale 1ns/1ps
module prbs_ref_comparator_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic start = 0, search = 0, lock = 0, bit_en = 0, rx = 0, clr = 0;
    logic ref_bit, err_stb;
    logic [31:0] err_cnt, bit_cnt;

    prbs_ref_comparator u_prbs_ref_comparator (
        .clk(clk), .rst(rst), .start_i(start), .search_i(search),
        .lock_i(lock), .bit_en_i(bit_en), .rx_bit_i(rx), .cnt_clr_i(clr),
        .ref_bit_o(ref_bit), .err_stb_o(err_stb),
        .err_cnt_o(err_cnt), .bit_cnt_o(bit_cnt));

    // small counters for saturation
    logic s_lock = 0, s_rx = 0, s_ref, s_stb;
    logic [3:0] s_err, s_bits;
    prbs_ref_comparator #(.STAGES(10), .CNT_W(4)) u_prbs_ref_comparator_sat (
        .clk(clk), .rst(rst), .start_i(1'b0), .search_i(1'b0),
        .lock_i(s_lock), .bit_en_i(1'b1), .rx_bit_i(s_rx), .cnt_clr_i(1'b0),
        .ref_bit_o(s_ref), .err_stb_o(s_stb),
        .err_cnt_o(s_err), .bit_cnt_o(s_bits));

    // five-stage variant
    logic f_lock = 0, f_ref, f_stb;
    logic [31:0] f_err, f_bits;
    prbs_ref_comparator #(.STAGES(5)) u_prbs_ref_comparator_five (
        .clk(clk), .rst(rst), .start_i(1'b0), .search_i(1'b0),
        .lock_i(f_lock), .bit_en_i(1'b1), .rx_bit_i(1'b0), .cnt_clr_i(1'b0),
        .ref_bit_o(f_ref), .err_stb_o(f_stb),
        .err_cnt_o(f_err), .bit_cnt_o(f_bits));

    int n_tests = 0;
    int n_fail  = 0;

    // reference model in stage order 1..10
    localparam logic [1:10] PRE = 10'b0001010111;
    logic [1:10] m = PRE;
    logic [31:0] m_err = 0, m_bits = 0;
    logic        last_ref;

    function automatic logic [1:10] step(input logic [1:10] s);
        return {s[3] ^ s[10], s[1:9]};
    endfunction

    typedef struct {
        logic        stb;
        logic        rb;
        logic [31:0] ec;
        logic [31:0] bc;
        string       tag;
    } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive_bit(input logic r, input logic lk, input logic en,
                             input logic sr, input logic st, input logic cl,
                             input string tag);
        exp_t e;
        @(negedge clk);
        last_ref = ref_bit;
        rx = r; lock = lk; bit_en = en; search = sr; start = st; clr = cl;
        e.stb = 1'b0;
        if (sr || st) begin
            m = PRE;
        end else if (lk && en) begin
            e.stb = r ^ m[10];
            m = step(m);
            if (m_bits != 32'hFFFF_FFFF) m_bits++;
            if (e.stb && m_err != 32'hFFFF_FFFF) m_err++;
        end
        if (cl) begin m_err = 0; m_bits = 0; end
        e.rb = m[10]; e.ec = m_err; e.bc = m_bits; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drive_cmp(input logic flip, input string tag);
        drive_bit(m[10] ^ flip, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: pops expected items and compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (err_stb !== e.stb || ref_bit !== e.rb ||
                    err_cnt !== e.ec || bit_cnt !== e.bc) begin
                    n_fail++;
                    $display("FAIL %s stb/ref/err/bits actual=%0b/%0b/%0d/%0d expected=%0b/%0b/%0d/%0d",
                             e.tag, err_stb, ref_bit, err_cnt, bit_cnt,
                             e.stb, e.rb, e.ec, e.bc);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic seq[2046];
        int   ones;
        int   dly;
        int   flips;
        int   locked_bits;
        logic [1:10] t;
        logic tb_q[$];
        logic tp_q[$];
        logic got_lock;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        // R1: reset state
        check(ref_bit === 1'b1, "R1", "ref_bit", ref_bit, 1);
        check(err_cnt == 0 && bit_cnt == 0, "R1", "counters", err_cnt + bit_cnt, 0);
        check(err_stb === 1'b0, "R1", "err_stb", err_stb, 0);

        // R5: start presets
        drive_bit(0, 0, 0, 0, 1, 0, "R5");

        // R2: long locked run with matching data, capture reference
        for (int i = 0; i < 2046; i++) begin
            drive_cmp(1'b0, "R2");
            seq[i] = last_ref;
        end
        ones = 0;
        for (int i = 0; i < 1023; i++) ones += int'(seq[i]);
        check(ones == 512, "R2", "ones per period", ones, 512);
        begin
            int bad = 0;
            for (int i = 0; i < 1023; i++) if (seq[i] !== seq[i+1023]) bad++;
            check(bad == 0, "R2", "period mismatches", bad, 0);
        end

        // R3: unlocked, random data and enable
        for (int i = 0; i < 30; i++)
            drive_bit(1'($urandom), 0, 1'($urandom), 0, 0, 0, "R3");
        // R10: locked but no bit enable
        for (int i = 0; i < 10; i++)
            drive_bit(1'($urandom), 1, 0, 0, 0, 0, "R10");

        // R6/R7: injected mismatches
        for (int i = 0; i < 40; i++) drive_cmp(1'(i % 3 == 0), "R6_R7");

        // R4: search while locked and enabled; no compare
        drive_bit(~m[10], 1, 1, 1, 0, 0, "R4");
        for (int i = 0; i < 12; i++) drive_cmp(1'b0, "R4");
        // R5: start while locked
        drive_bit(~m[10], 1, 1, 0, 1, 0, "R5");
        drive_cmp(1'b0, "R5");

        // R9: clear coincides with a mismatched compared bit
        drive_bit(~m[10], 1, 1, 0, 0, 1, "R9");
        drive_cmp(1'b1, "R9");

        // R11: identical generator through delay and flip channel
        dly   = 3 + int'($urandom % 38);
        flips = 0;
        locked_bits = 0;
        got_lock = 1'b0;
        t = 10'b1000000001;
        drive_bit(0, 0, 0, 1, 0, 1, "R11");
        for (int i = 0; i < 1023 + dly + 1500; i++) begin
            logic ob, op, fl;
            tb_q.push_back(t[10]);
            tp_q.push_back(t == PRE);
            t = step(t);
            if (tb_q.size() > dly) begin
                ob = tb_q.pop_front();
                op = tp_q.pop_front();
                if (op) got_lock = 1'b1;
                if (got_lock) begin
                    fl = ($urandom % 50) == 0;
                    flips += int'(fl);
                    locked_bits++;
                    drive_bit(ob ^ fl, 1, 1, 0, 0, 0, "R11");
                end else begin
                    drive_bit(1'($urandom), 0, 1, 0, 0, 0, "R11");
                end
            end else begin
                drive_bit(1'($urandom), 0, 1, 0, 0, 0, "R11");
            end
        end
        @(posedge clk); #2;
        check(err_cnt == 32'(flips), "R11", "errors vs flips", err_cnt, flips);
        check(bit_cnt == 32'(locked_bits), "R11", "bits", bit_cnt, locked_bits);
        @(negedge clk); lock = 0; bit_en = 0;

        // R8: saturation on a 4-bit counter build
        s_lock = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            s_rx = ~s_ref;
        end
        @(negedge clk); s_lock = 1'b0;
        @(posedge clk); #2;
        check(s_err == 4'hF, "R8", "sat err", s_err, 15);
        check(s_bits == 4'hF, "R8", "sat bits", s_bits, 15);

        // R12: five-stage variant
        @(negedge clk);
        check(f_ref === 1'b1, "R12", "preset output", f_ref, 1);
        f_lock = 1'b1;
        for (int i = 0; i < 62; i++) begin
            seq[i] = f_ref;
            @(negedge clk);
        end
        f_lock = 1'b0;
        ones = 0;
        for (int i = 0; i < 31; i++) ones += int'(seq[i]);
        check(ones == 16, "R12", "ones per period", ones, 16);
        begin
            int bad = 0;
            for (int i = 0; i < 31; i++) if (seq[i] !== seq[i+31]) bad++;
            check(bad == 0, "R12", "period mismatches", bad, 0);
        end

        repeat (3) @(posedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule